// File: doc/BRIEF.md
# Strobe-Synchronized Bus Slave Capture

This block is the receiving front end of a parallel backplane slave that runs entirely on one fast system clock. The address strobe and the two data strobes arrive asynchronously and active low. Each is brought into the fast clock domain through its own two-flop synchronizer. Edges of the synchronized strobes are never used as clocks. They act as load enables for capture registers clocked by the fast clock. The address, address-modifier and long-word lines are taken on the synchronized falling edge of the address strobe. The data lines are taken once the address is held and either data strobe is seen low.

The synchronizer delay is safe because of the bus contract. The master presents data well ahead of the strobe's falling edge and keeps it there until the slave answers. The slave answers by driving its transfer-acknowledge output low, which happens only after the data register is loaded. The acknowledge stays low until both data strobes return high. A one-cycle write-valid pulse marks the cycle in which fresh address, modifier, long-word and data values are first presented at the outputs.

The controller is a Moore state machine with five states:
- IDLE waits for a synchronized address-strobe fall and leaves for ADDR_HELD.
- ADDR_HELD leaves for DATA_TAKEN when either data strobe is low. It aborts back to IDLE if the address strobe rises first.
- DATA_TAKEN always moves to ACKING after one cycle.
- ACKING leaves when both data strobes are high. It goes to IDLE if the address strobe is already high, and to WAIT_AS_HIGH if it is not.
- WAIT_AS_HIGH returns to IDLE once the address strobe is high.

Top module: `bus_strobe_capture`

## Requirements
- R1: Every strobe passes through two synchronizer flops. A strobe driven low just after a rising clock edge has its effect registered on the third rising edge after that change, and not before.
- R2: From IDLE, a synchronized falling edge of the address strobe loads the address, address-modifier and long-word lines into the latched outputs.
- R3: In ADDR_HELD, while the address strobe is still low, the data lines are loaded on the first edge where either synchronized data strobe is low. This happens exactly once per cycle. Later changes on the data lines within the same cycle do not reach the latched data.
- R4: `wr_valid` is high for exactly the one cycle following the data load. During that cycle the latched data already holds the captured value.
- R5: `ack_n` goes low one clock after `wr_valid`. It stays low while either synchronized data strobe is low. It returns high on the third rising edge after both data strobes are driven high.
- R6: Once the address has been taken, no new address is loaded, even if the address strobe pulses, until the controller is back in IDLE.
- R7: In IDLE, a data strobe going low has no effect: `wr_valid` stays 0, `ack_n` stays 1, and the latched data is unchanged.
- R8: If the address strobe returns high in ADDR_HELD before any data strobe is seen low, the controller returns to IDLE with no data load and no acknowledge.
- R9: `rst_n` is asynchronous and active low. Reset forces `ack_n`=1, `wr_valid`=0 and `lat_lword_n`=1, and clears `lat_addr`, `lat_am` and `lat_data` to 0, all without a clock edge.
- R10: After the acknowledge is released, the controller returns to IDLE only once the address strobe is high. Until then a data strobe going low causes neither a load nor an acknowledge. A full cycle afterwards works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| as_n_async | input | 1 | Address strobe from the bus, active low, asynchronous |
| ds_n_async | input | 2 | Data strobes from the bus, active low, asynchronous |
| addr_bus | input | ADDR_W | Address lines |
| am_bus | input | AM_W | Address-modifier lines |
| lword_n_bus | input | 1 | Long-word line, active low |
| data_bus | input | DATA_W | Data lines |
| ack_n | output | 1 | Transfer acknowledge, active low |
| wr_valid | output | 1 | One-cycle pulse when a write has been captured |
| lat_addr | output | ADDR_W | Latched address |
| lat_am | output | AM_W | Latched address modifier |
| lat_lword_n | output | 1 | Latched long-word, active low |
| lat_data | output | DATA_W | Latched data |

## Verification
A controller stuck or misrouted between states shows at the ports within a few clocks. An acknowledge that never falls or never rises gives a late or missing `ack_n` edge. A skipped DATA_TAKEN state gives a missing `wr_valid` pulse. A controller that fails to leave IDLE after an abort, or leaves it too early, gives a capture or acknowledge where none should occur. A wrong synchronizer depth shifts the address load and the `wr_valid` pulse by one edge. The directed tests sample at the exact edge count from each strobe change, so such a shift is caught. Re-pulsing the address strobe during ACKING, and dropping data strobes in IDLE and in WAIT_AS_HIGH, expose enables that leak outside their state, because stale or fresh values then appear on the latched outputs.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_ADDR_HELD = 3'd1,
        ST_DATA_TAKEN= 3'd2,
        ST_ACKING    = 3'd3,
        ST_WAIT_AS   = 3'd4
    } bsc_state_e;

    localparam int unsigned NUM_DS = 2;

endpackage

// File: rtl/bsc_sync2.sv
module bsc_sync2 #(
    parameter int unsigned WIDTH   = 3,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    // one independent two-stage chain per line
    for (genvar g = 0; g < WIDTH; g++) begin : g_chain
        logic stage1;
        logic stage2;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1 <= RST_VAL;
                stage2 <= RST_VAL;
            end else begin
                stage1 <= d_async[g];
                stage2 <= stage1;
            end
        end

        assign q_sync[g] = stage2;
    end

endmodule

// File: rtl/bsc_ctrl.sv
module bsc_ctrl
    import bsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_s,      // synchronized address strobe, active low
    input  logic [NUM_DS-1:0] ds_s,      // synchronized data strobes, active low
    output logic              addr_take,
    output logic              data_take,
    output logic              in_idle,
    output logic              wr_valid,
    output logic              ack_n
);

    bsc_state_e state_q;
    bsc_state_e state_d;
    logic       as_prev_q;
    logic       as_fall;
    logic       ds_low;

    assign as_fall = as_prev_q & ~as_s;
    assign ds_low  = ~(&ds_s);

    // state register and edge-detect history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            as_prev_q <= 1'b1;
        end else begin
            state_q   <= state_d;
            as_prev_q <= as_s;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (as_fall) state_d = ST_ADDR_HELD;
            end
            ST_ADDR_HELD: begin
                if (as_s)        state_d = ST_IDLE;
                else if (ds_low) state_d = ST_DATA_TAKEN;
            end
            ST_DATA_TAKEN: begin
                state_d = ST_ACKING;
            end
            ST_ACKING: begin
                if (!ds_low) state_d = as_s ? ST_IDLE : ST_WAIT_AS;
            end
            ST_WAIT_AS: begin
                if (as_s) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        addr_take = 1'b0;
        data_take = 1'b0;
        in_idle   = 1'b0;
        wr_valid  = 1'b0;
        ack_n     = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                in_idle   = 1'b1;
                addr_take = as_fall;
            end
            ST_ADDR_HELD: begin
                data_take = ~as_s & ds_low;
            end
            ST_DATA_TAKEN: begin
                wr_valid = 1'b1;
            end
            ST_ACKING: begin
                ack_n = 1'b0;
            end
            ST_WAIT_AS: begin
                ack_n = 1'b1;
            end
            default: begin
                in_idle = 1'b0;
            end
        endcase
    end

    // R5: acknowledge follows the write-valid pulse by one clock
    assert_ack_after_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !ack_n);

    // R5: acknowledge held while a data strobe is still low
    assert_ack_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && ds_low) |=> !ack_n);

    // R4: the valid pulse lasts a single cycle
    assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    // R3: a capture is only reported after a data strobe was seen low
    assert_valid_needs_ds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(ds_low));

    // R8: an aborted address phase yields neither valid nor acknowledge
    assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR_HELD && as_s) |=> (ack_n && !wr_valid));

endmodule

// File: rtl/bsc_capture.sv
module bsc_capture #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned AM_W   = 6,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_take,
    input  logic              data_take,
    input  logic [ADDR_W-1:0] addr_bus,
    input  logic [AM_W-1:0]   am_bus,
    input  logic              lword_n_bus,
    input  logic [DATA_W-1:0] data_bus,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [AM_W-1:0]   lat_am,
    output logic              lat_lword_n,
    output logic [DATA_W-1:0] lat_data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr    <= '0;
            lat_am      <= '0;
            lat_lword_n <= 1'b1;
        end else if (addr_take) begin
            lat_addr    <= addr_bus;
            lat_am      <= am_bus;
            lat_lword_n <= lword_n_bus;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_data <= '0;
        end else if (data_take) begin
            lat_data <= data_bus;
        end
    end

endmodule

// File: rtl/bus_strobe_capture.sv
module bus_strobe_capture
    import bsc_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned AM_W   = 6,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_n_async,
    input  logic [1:0]        ds_n_async,
    input  logic [ADDR_W-1:0] addr_bus,
    input  logic [AM_W-1:0]   am_bus,
    input  logic              lword_n_bus,
    input  logic [DATA_W-1:0] data_bus,
    output logic              ack_n,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [AM_W-1:0]   lat_am,
    output logic              lat_lword_n,
    output logic [DATA_W-1:0] lat_data
);

    localparam int unsigned STROBES = NUM_DS + 1;

    logic [STROBES-1:0] strobe_s;
    logic               as_s;
    logic [NUM_DS-1:0]  ds_s;
    logic               addr_take;
    logic               data_take;
    logic               in_idle;

    bsc_sync2 #(
        .WIDTH   (STROBES),
        .RST_VAL (1'b1)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({as_n_async, ds_n_async}),
        .q_sync  (strobe_s)
    );

    assign as_s = strobe_s[STROBES-1];
    assign ds_s = strobe_s[NUM_DS-1:0];

    bsc_ctrl ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .as_s      (as_s),
        .ds_s      (ds_s),
        .addr_take (addr_take),
        .data_take (data_take),
        .in_idle   (in_idle),
        .wr_valid  (wr_valid),
        .ack_n     (ack_n)
    );

    bsc_capture #(
        .ADDR_W (ADDR_W),
        .AM_W   (AM_W),
        .DATA_W (DATA_W)
    ) cap_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_take   (addr_take),
        .data_take   (data_take),
        .addr_bus    (addr_bus),
        .am_bus      (am_bus),
        .lword_n_bus (lword_n_bus),
        .data_bus    (data_bus),
        .lat_addr    (lat_addr),
        .lat_am      (lat_am),
        .lat_lword_n (lat_lword_n),
        .lat_data    (lat_data)
    );

    // R6: latched address frozen whenever the controller is outside IDLE
    assert_addr_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_idle |=> $stable(lat_addr));

    // R4: data register already loaded while the valid pulse is shown
    assert_data_before_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(data_take));

endmodule

// File: tb/bus_strobe_capture_tb_top.sv
module bus_strobe_capture_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        as_n = 1'b1;
    logic [1:0]  ds_n = 2'b11;
    logic [31:0] addr = '0;
    logic [5:0]  am = '0;
    logic        lword_n = 1'b1;
    logic [31:0] data = '0;
    logic        ack_n;
    logic        wr_valid;
    logic [31:0] lat_addr;
    logic [5:0]  lat_am;
    logic        lat_lword_n;
    logic [31:0] lat_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] exp_addr = '0;
    logic [31:0] exp_data = '0;

    always #10 clk = ~clk;

    bus_strobe_capture dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .as_n_async  (as_n),
        .ds_n_async  (ds_n),
        .addr_bus    (addr),
        .am_bus      (am),
        .lword_n_bus (lword_n),
        .data_bus    (data),
        .ack_n       (ack_n),
        .wr_valid    (wr_valid),
        .lat_addr    (lat_addr),
        .lat_am      (lat_am),
        .lat_lword_n (lat_lword_n),
        .lat_data    (lat_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // n rising edges, then settle on the falling edge
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        check("R9 ack_n", {31'd0, ack_n}, 32'd1);
        check("R9 wr_valid", {31'd0, wr_valid}, 32'd0);
        check("R9 lat_addr", lat_addr, 32'd0);
        check("R9 lat_am", {26'd0, lat_am}, 32'd0);
        check("R9 lat_lword_n", {31'd0, lat_lword_n}, 32'd1);
        check("R9 lat_data", lat_data, 32'd0);
    endtask

    task automatic t_write(input logic [31:0] a, input logic [5:0] m, input logic lw,
                           input logic [31:0] d, input logic [1:0] mask);
        addr = a; am = m; lword_n = lw; data = d; as_n = 1'b0;
        step(2);
        check("R1 addr not yet taken", lat_addr, exp_addr);
        step(1);
        exp_addr = a;
        check("R2 lat_addr", lat_addr, a);
        check("R2 lat_am", {26'd0, lat_am}, {26'd0, m});
        check("R2 lat_lword_n", {31'd0, lat_lword_n}, {31'd0, lw});
        ds_n = ~mask;
        step(2);
        check("R1 no early valid", {31'd0, wr_valid}, 32'd0);
        step(1);
        exp_data = d;
        check("R3 lat_data", lat_data, d);
        check("R4 wr_valid high", {31'd0, wr_valid}, 32'd1);
        data = ~d;
        step(1);
        check("R4 wr_valid single", {31'd0, wr_valid}, 32'd0);
        check("R5 ack low", {31'd0, ack_n}, 32'd0);
        step(5);
        check("R5 ack held", {31'd0, ack_n}, 32'd0);
        check("R3 data taken once", lat_data, d);
        check("R4 no second valid", {31'd0, wr_valid}, 32'd0);
        ds_n = 2'b11;
        step(2);
        check("R5 ack still low", {31'd0, ack_n}, 32'd0);
        step(1);
        check("R5 ack released", {31'd0, ack_n}, 32'd1);
        as_n = 1'b1;
        step(4);
    endtask

    task automatic t_ds_in_idle();
        data = 32'h1111_2222;
        ds_n = 2'b00;
        step(6);
        check("R7 no valid", {31'd0, wr_valid}, 32'd0);
        check("R7 no ack", {31'd0, ack_n}, 32'd1);
        check("R7 data kept", lat_data, exp_data);
        ds_n = 2'b11;
        step(4);
    endtask

    task automatic t_as_retoggle();
        addr = 32'hCAFE_0001; am = 6'h09; lword_n = 1'b0; data = 32'h0BAD_F00D;
        as_n = 1'b0;
        step(3);
        exp_addr = 32'hCAFE_0001;
        ds_n = 2'b10;
        step(4);
        exp_data = 32'h0BAD_F00D;
        check("R5 ack in retoggle", {31'd0, ack_n}, 32'd0);
        addr = 32'h7777_7777;
        as_n = 1'b1;
        step(3);
        as_n = 1'b0;
        step(4);
        check("R6 addr frozen", lat_addr, exp_addr);
        check("R6 ack kept", {31'd0, ack_n}, 32'd0);
        ds_n = 2'b11;
        step(3);
        check("R6 ack released", {31'd0, ack_n}, 32'd1);
        check("R6 addr still frozen", lat_addr, exp_addr);
        data = 32'h5555_AAAA;
        ds_n = 2'b00;
        step(5);
        check("R10 no valid before AS high", {31'd0, wr_valid}, 32'd0);
        check("R10 no ack before AS high", {31'd0, ack_n}, 32'd1);
        check("R10 data kept", lat_data, exp_data);
        ds_n = 2'b11;
        as_n = 1'b1;
        step(4);
    endtask

    task automatic t_abort();
        addr = 32'h0000_ABCD; am = 6'h2A; lword_n = 1'b1;
        as_n = 1'b0;
        step(3);
        exp_addr = 32'h0000_ABCD;
        check("R8 addr taken", lat_addr, exp_addr);
        as_n = 1'b1;
        step(4);
        data = 32'h9999_0000;
        ds_n = 2'b00;
        step(5);
        check("R8 no ack", {31'd0, ack_n}, 32'd1);
        check("R8 no valid", {31'd0, wr_valid}, 32'd0);
        check("R8 data kept", lat_data, exp_data);
        ds_n = 2'b11;
        step(4);
    endtask

    task automatic t_async_reset();
        addr = 32'h1357_9BDF; am = 6'h3F; lword_n = 1'b0; data = 32'h2468_ACE0;
        as_n = 1'b0;
        step(3);
        ds_n = 2'b01;
        step(4);
        check("R9 pre-reset ack", {31'd0, ack_n}, 32'd0);
        #3 rst_n = 1'b0;
        #1;
        check("R9 async ack_n", {31'd0, ack_n}, 32'd1);
        check("R9 async lat_addr", lat_addr, 32'd0);
        check("R9 async lat_data", lat_data, 32'd0);
        check("R9 async lat_lword_n", {31'd0, lat_lword_n}, 32'd1);
        exp_addr = '0; exp_data = '0;
        as_n = 1'b1; ds_n = 2'b11;
        step(2);
        rst_n = 1'b1;
        step(4);
    endtask

    initial begin
        step(3);
        t_reset_state();
        rst_n = 1'b1;
        step(2);
        t_write(32'h00A5_1230, 6'h3D, 1'b0, 32'hDEAD_BEEF, 2'b01);
        t_write(32'h8000_0004, 6'h0D, 1'b1, 32'h0123_4567, 2'b10);
        t_ds_in_idle();
        t_as_retoggle();
        t_write(32'h4242_4240, 6'h39, 1'b0, 32'hFEED_C0DE, 2'b11); // R10 fresh cycle
        t_abort();
        t_async_reset();
        t_write(32'h0F0F_0F0C, 6'h11, 1'b1, 32'hA5A5_5A5A, 2'b01);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule